// File: doc/BRIEF.md
# Interrupt Destination Match Unit

This block sits beside a local interrupt controller and decides, for each interrupt message presented to it, whether the local unit should take that message. Each message carries a destination field, a flag that says whether the field is a physical or a logical address, and a shorthand code. The unit compares these against its own physical identifier, its logical identifier register and its flat/cluster format setting. One registered verdict per message comes out one clock later.

Physical addressing compares identifiers. In legacy mode the comparison uses an 8-bit identifier, and in extended mode it uses the full 32-bit identifier. Each mode has its own all-ones broadcast value. Logical addressing works in one of two formats. In flat format the 8-bit logical identifier is a bitmask. In cluster format the logical identifier is a 4-bit cluster number followed by a 4-bit member mask. Two shorthands skip the destination field: one targets only the sending unit, and one targets every unit. A verdict depends only on the local unit's own state. So units that share an identifier all accept, and destination bits that name absent units change nothing.

Top module: `irq_dest_match`

## Requirements
- R1: `out_valid` goes high exactly one clock after a cycle with `in_valid` high, and low otherwise. `out_accept` is low whenever `out_valid` is low.
- R2: Shorthand code 2'b01 (self) is accepted only if `in_from_self` is 1. The destination field and the mode flag are ignored.
- R3: Shorthand code 2'b10 (all-including) is always accepted, whatever the destination, the mode flag or the configuration.
- R4: Shorthand code 2'b11 is reserved and is never accepted.
- R5: With shorthand 2'b00, `in_logical`=0 and `cfg_ext_mode`=0, a message is accepted when `in_dest[7:0]` equals `cfg_phys_id[31:24]`. `in_dest[31:8]` is ignored. Acceptance depends only on the unit's own ID, so two units with equal IDs both accept.
- R6: In legacy physical addressing, `in_dest[7:0]`=8'hFF is accepted by every unit.
- R7: With `cfg_ext_mode`=1, physical addressing compares all 32 bits of `in_dest` with `cfg_phys_id`. 32'hFFFFFFFF is accepted by every unit, and 8'hFF is not a broadcast in this mode.
- R8: With `in_logical`=1 and `cfg_cluster`=0 (flat), a message is accepted when `in_dest[7:0]` AND `cfg_logical_reg[31:24]` is nonzero. Extra set bits naming other units do not block acceptance.
- R9: With `in_logical`=1 and `cfg_cluster`=1, a message is accepted when `in_dest[7:4]` equals `cfg_logical_reg[31:28]` and `in_dest[3:0]` AND `cfg_logical_reg[27:24]` is nonzero.
- R10: A logical destination `in_dest[7:0]`=8'hFF is accepted by every unit in both formats. Otherwise a logical ID of zero never matches.
- R11: While `rst_n` is low, `out_valid` and `out_accept` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A message is present this cycle |
| in_dest | input | 32 | Destination field |
| in_logical | input | 1 | 1 = logical addressing, 0 = physical |
| in_shorthand | input | 2 | 00 none, 01 self, 10 all-including, 11 reserved |
| in_from_self | input | 1 | The message was sent by this unit |
| cfg_ext_mode | input | 1 | 1 = extended 32-bit physical IDs |
| cfg_phys_id | input | 32 | Local physical ID (legacy ID in bits 31:24) |
| cfg_logical_reg | input | 32 | Logical ID register (ID in bits 31:24) |
| cfg_cluster | input | 1 | 1 = cluster logical format, 0 = flat |
| out_valid | output | 1 | Verdict present |
| out_accept | output | 1 | The local unit accepts the message |

## Verification
- **Physical matching:** exact and mismatching IDs are tried in both physical widths. Junk is placed in the upper destination bits, which separates the legacy comparison from the extended one. The value 8'hFF is sent in both modes, which shows that the broadcast value depends on the mode.
- **Aliasing:** a second instance with the same ID shows that aliased units both accept. Giving it a different ID shows that it rejects.
- **Flat logical matching:** masks with extra foreign bits show that overlap, not equality, decides acceptance.
- **Cluster logical matching:** patterns with the right cluster but a disjoint member mask, and with the wrong cluster but an overlapping mask, separate the two halves of the cluster test.
- **Zero logical ID:** this case separates broadcast from plain overlap.
- **Shorthands:** each code is sent with a destination that would give the opposite verdict, which shows that the destination field is ignored.

// File: rtl/irq_dest_match_pkg.sv
package irq_dest_match_pkg;

    typedef enum logic [1:0] {
        SH_NONE     = 2'b00,
        SH_SELF     = 2'b01,
        SH_ALL_INCL = 2'b10,
        SH_RSVD     = 2'b11
    } shorthand_e;

    typedef struct packed {
        logic valid;
        logic accept;
    } verdict_t;

endpackage

// File: rtl/dm_phys_cmp.sv
module dm_phys_cmp #(
    parameter int PHYS_W = 32,
    parameter int LEG_W  = 8
) (
    input  logic [PHYS_W-1:0] dest,
    input  logic [PHYS_W-1:0] own_id,
    input  logic              ext_mode,
    output logic              hit
);
    localparam int LEG_LSB = PHYS_W - LEG_W;

    logic leg_hit;
    logic ext_hit;

    // Legacy form: low byte of the destination against the top byte of the ID.
    generate
        if (LEG_W == PHYS_W) begin : g_same_width
            assign leg_hit = (dest == own_id) || (&dest);
        end else begin : g_narrow
            logic [LEG_W-1:0] dest_leg;
            logic [LEG_W-1:0] id_leg;
            assign dest_leg = dest[LEG_W-1:0];
            assign id_leg   = own_id[PHYS_W-1:LEG_LSB];
            assign leg_hit  = (dest_leg == id_leg) || (&dest_leg);
        end
    endgenerate

    assign ext_hit = (dest == own_id) || (&dest);
    assign hit     = ext_mode ? ext_hit : leg_hit;

endmodule

// File: rtl/dm_log_cmp.sv
module dm_log_cmp #(
    parameter int REG_W = 32,
    parameter int LID_W = 8,
    parameter int CL_W  = 4
) (
    input  logic [LID_W-1:0] dest,
    input  logic [REG_W-1:0] lid_reg,
    input  logic             cluster,
    output logic             hit
);
    localparam int LID_LSB = REG_W - LID_W;
    localparam int MEM_W   = LID_W - CL_W;

    logic [LID_W-1:0]   lid;
    logic [LID_LSB-1:0] unused_low;
    logic [LID_W-1:0]   overlap;
    logic               bcast;
    logic               flat_hit;
    logic               clus_hit;

    assign lid        = lid_reg[REG_W-1:LID_LSB];
    assign unused_low = lid_reg[LID_LSB-1:0];

    generate
        for (genvar b = 0; b < LID_W; b++) begin : g_bit
            assign overlap[b] = dest[b] & lid[b];
        end
    endgenerate

    assign bcast    = &dest;
    assign flat_hit = |overlap;
    assign clus_hit = (dest[LID_W-1:MEM_W] == lid[LID_W-1:MEM_W]) &&
                      (|overlap[MEM_W-1:0]);
    assign hit      = bcast || (cluster ? clus_hit : flat_hit);

endmodule

// File: rtl/dm_route.sv
module dm_route
    import irq_dest_match_pkg::*;
(
    input  shorthand_e sh,
    input  logic       from_self,
    input  logic       logical,
    input  logic       phys_hit,
    input  logic       log_hit,
    output logic       accept
);
    always_comb begin
        unique case (sh)
            SH_SELF:     accept = from_self;
            SH_ALL_INCL: accept = 1'b1;
            SH_RSVD:     accept = 1'b0;
            default:     accept = logical ? log_hit : phys_hit;
        endcase
    end
endmodule

// File: rtl/irq_dest_match.sv
module irq_dest_match
    import irq_dest_match_pkg::*;
#(
    parameter int PHYS_W = 32,
    parameter int LEG_W  = 8,
    parameter int CL_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [PHYS_W-1:0] in_dest,
    input  logic              in_logical,
    input  logic [1:0]        in_shorthand,
    input  logic              in_from_self,
    input  logic              cfg_ext_mode,
    input  logic [PHYS_W-1:0] cfg_phys_id,
    input  logic [PHYS_W-1:0] cfg_logical_reg,
    input  logic              cfg_cluster,
    output logic              out_valid,
    output logic              out_accept
);
    localparam int LEG_LSB = PHYS_W - LEG_W;

    verdict_t   st_d;
    verdict_t   st_q;
    shorthand_e sh;
    logic       phys_hit;
    logic       log_hit;
    logic       route_acc;

    assign sh = shorthand_e'(in_shorthand);

    dm_phys_cmp #(.PHYS_W(PHYS_W), .LEG_W(LEG_W)) i_phys (
        .dest     (in_dest),
        .own_id   (cfg_phys_id),
        .ext_mode (cfg_ext_mode),
        .hit      (phys_hit)
    );

    dm_log_cmp #(.REG_W(PHYS_W), .LID_W(LEG_W), .CL_W(CL_W)) i_log (
        .dest    (in_dest[LEG_W-1:0]),
        .lid_reg (cfg_logical_reg),
        .cluster (cfg_cluster),
        .hit     (log_hit)
    );

    dm_route i_route (
        .sh        (sh),
        .from_self (in_from_self),
        .logical   (in_logical),
        .phys_hit  (phys_hit),
        .log_hit   (log_hit),
        .accept    (route_acc)
    );

    always_comb begin
        st_d        = st_q;
        st_d.valid  = in_valid;
        st_d.accept = in_valid & route_acc;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid  = st_q.valid;
    assign out_accept = st_q.accept;

    // Assertions next to the verdict register
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_accept));

    p_self_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_shorthand == 2'b01 && !in_from_self) |=> !out_accept);

    p_all_incl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_shorthand == 2'b10) |=> (out_valid && out_accept));

    p_rsvd_never_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_shorthand == 2'b11) |=> !out_accept);

    p_leg_bcast_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_shorthand == 2'b00 && !in_logical && !cfg_ext_mode &&
         (&in_dest[LEG_W-1:0])) |=> out_accept);

    p_leg_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_shorthand == 2'b00 && !in_logical && !cfg_ext_mode &&
         in_dest[LEG_W-1:0] == cfg_phys_id[PHYS_W-1:LEG_LSB]) |=> out_accept);

    p_ext_bcast_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_shorthand == 2'b00 && !in_logical && cfg_ext_mode &&
         (&in_dest)) |=> out_accept);

    p_log_bcast_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_shorthand == 2'b00 && in_logical &&
         (&in_dest[LEG_W-1:0])) |=> out_accept);

endmodule

// File: tb/test_irq_dest_match.sv
`timescale 1ns/1ps
module test_irq_dest_match;

    typedef struct packed {
        logic acc;
        logic twin_acc;
        logic [7:0] req;
    } exp_t;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        in_valid = 0;
    logic [31:0] in_dest = '0;
    logic        in_logical = 0;
    logic [1:0]  in_shorthand = 2'b00;
    logic        in_from_self = 0;
    logic        cfg_ext_mode = 0;
    logic [31:0] cfg_phys_id = '0;
    logic [31:0] twin_phys_id = '0;
    logic [31:0] cfg_logical_reg = '0;
    logic        cfg_cluster = 0;
    logic        out_valid, out_accept;
    logic        twin_valid, twin_accept;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 0;
    exp_t q[$];

    always #4 clk = ~clk;

    irq_dest_match i_irq_dest_match (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dest(in_dest),
        .in_logical(in_logical), .in_shorthand(in_shorthand),
        .in_from_self(in_from_self), .cfg_ext_mode(cfg_ext_mode),
        .cfg_phys_id(cfg_phys_id), .cfg_logical_reg(cfg_logical_reg),
        .cfg_cluster(cfg_cluster), .out_valid(out_valid), .out_accept(out_accept)
    );

    irq_dest_match i_twin (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dest(in_dest),
        .in_logical(in_logical), .in_shorthand(in_shorthand),
        .in_from_self(in_from_self), .cfg_ext_mode(cfg_ext_mode),
        .cfg_phys_id(twin_phys_id), .cfg_logical_reg(cfg_logical_reg),
        .cfg_cluster(cfg_cluster), .out_valid(twin_valid), .out_accept(twin_accept)
    );

    function automatic bit model(input logic [31:0] pid);
        logic [7:0] d8;
        logic [7:0] l8;
        d8 = in_dest[7:0];
        l8 = cfg_logical_reg[31:24];
        case (in_shorthand)
            2'b01: return in_from_self;
            2'b10: return 1'b1;
            2'b11: return 1'b0;
            default: begin
                if (!in_logical) begin
                    if (cfg_ext_mode) return (in_dest == 32'hFFFF_FFFF) || (in_dest == pid);
                    return (d8 == 8'hFF) || (d8 == pid[31:24]);
                end
                if (d8 == 8'hFF) return 1'b1;
                if (cfg_cluster) return (d8[7:4] == l8[7:4]) && ((d8[3:0] & l8[3:0]) != 0);
                return (d8 & l8) != 0;
            end
        endcase
    endfunction

    task automatic check(input bit ok, input int req, input logic act, input logic exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL R%0d: actual %0b expected %0b", req, act, exp);
        end
    endtask

    // Driver: present one message per call, push its expected verdict
    task automatic send(input int req, input logic [1:0] sh, input logic self,
                        input logic logical, input logic [31:0] dest);
        exp_t e;
        @(negedge clk);
        in_valid = 1; in_shorthand = sh; in_from_self = self;
        in_logical = logical; in_dest = dest;
        e.acc = model(cfg_phys_id);
        e.twin_acc = model(twin_phys_id);
        e.req = 8'(req);
        q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 0;
        end
    endtask

    // Monitor: after each edge, pop and compare
    always begin
        @(posedge clk);
        #1;
        if (rst_n && !done) begin
            if (out_valid) begin
                if (q.size() == 0) begin
                    check(0, 1, out_valid, 1'b0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(out_accept === e.acc, int'(e.req), out_accept, e.acc);
                    check(twin_accept === e.twin_acc, int'(e.req), twin_accept, e.twin_acc);
                end
            end else if (out_accept !== 1'b0) begin
                check(0, 1, out_accept, 1'b0); // R1 accept low without valid
            end
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1;
            n_tests++; n_fail++;
            $display("FAIL R1: watchdog expired, actual hang expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R11 reset state
        in_valid = 1; in_shorthand = 2'b10;
        repeat (3) @(negedge clk);
        check(out_valid === 1'b0, 11, out_valid, 1'b0);
        check(out_accept === 1'b0, 11, out_accept, 1'b0);
        in_valid = 0; in_shorthand = 2'b00;
        rst_n = 1;
        idle(2);
        check(out_valid === 1'b0, 1, out_valid, 1'b0); // R1 idle

        // R5 legacy physical, aliased twin
        cfg_phys_id = 32'h0500_0000; twin_phys_id = 32'h0500_0000;
        send(5, 2'b00, 0, 0, 32'h0000_0005);
        send(5, 2'b00, 0, 0, 32'hFFFF_FF05);
        send(5, 2'b00, 0, 0, 32'h0000_0006);
        twin_phys_id = 32'h0700_0000;
        send(5, 2'b00, 0, 0, 32'h0000_0005);
        // R6 legacy broadcast
        send(6, 2'b00, 0, 0, 32'h0000_00FF);
        idle(2);

        // R7 extended physical
        cfg_ext_mode = 1; cfg_phys_id = 32'h0000_0123; twin_phys_id = 32'h0000_0124;
        send(7, 2'b00, 0, 0, 32'h0000_0123);
        send(7, 2'b00, 0, 0, 32'h0000_00FF);
        send(7, 2'b00, 0, 0, 32'hFFFF_FFFF);
        send(7, 2'b00, 0, 0, 32'h0100_0123);
        idle(1);
        cfg_ext_mode = 0;

        // R8 flat logical
        cfg_cluster = 0; cfg_logical_reg = 32'h0400_0000;
        send(8, 2'b00, 0, 1, 32'h0000_0004);
        send(8, 2'b00, 0, 1, 32'h0000_000C);
        send(8, 2'b00, 0, 1, 32'h0000_0003);
        send(8, 2'b00, 0, 1, 32'hFFFF_FF00);
        idle(1);

        // R9 cluster logical
        cfg_cluster = 1; cfg_logical_reg = 32'h3200_0000;
        send(9, 2'b00, 0, 1, 32'h0000_0032);
        send(9, 2'b00, 0, 1, 32'h0000_003A);
        send(9, 2'b00, 0, 1, 32'h0000_0042);
        send(9, 2'b00, 0, 1, 32'h0000_0031);
        idle(1);

        // R10 zero logical ID and logical broadcast
        cfg_logical_reg = 32'h00AB_CDEF;
        send(10, 2'b00, 0, 1, 32'h0000_00FF);
        send(10, 2'b00, 0, 1, 32'h0000_000F);
        cfg_cluster = 0;
        send(10, 2'b00, 0, 1, 32'h0000_00FF);
        send(10, 2'b00, 0, 1, 32'h0000_007F);
        idle(1);

        // R2 self shorthand, destination would say otherwise
        cfg_phys_id = 32'h0500_0000; twin_phys_id = 32'h0500_0000;
        send(2, 2'b01, 1, 0, 32'h0000_0009);
        send(2, 2'b01, 0, 0, 32'h0000_0005);
        // R3 all-including
        send(3, 2'b10, 0, 0, 32'h0000_0009);
        send(3, 2'b10, 0, 1, 32'h0000_0000);
        // R4 reserved
        send(4, 2'b11, 1, 0, 32'h0000_00FF);
        send(4, 2'b11, 0, 1, 32'h0000_00FF);
        idle(4);

        check(q.size() == 0, 1, q.size() != 0, 1'b0); // R1 every message answered
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule